// File: doc/BRIEF.md
# Oversampling Serial Receive Engine with Error-Drop Policy

This block recovers asynchronous serial characters from a single receive line and writes each accepted character into a receive FIFO through a one-cycle write strobe. It runs from a system clock qualified by an oversample enable: one enable pulse per sixteenth of a bit. It resynchronises the line and waits for a high-to-low transition. It confirms that the line is still low halfway into the start bit, then samples every following bit at its centre. The character length is 5 to 9 bits, sent least significant bit first. An optional even or odd parity bit and one or two stop bits follow the character.

Two sticky status flags report receive errors. The framing flag covers both a start bit that turns out to be a glitch and a stop bit read as low. The parity flag covers a parity mismatch. Software clears a flag by writing 1 to its bit position. The FIFO entry holds only the character and carries no error marker. Two policy inputs therefore decide whether a character with a stop-bit error, or with a parity error, is written to the FIFO or thrown away.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset the FIFO write strobe is low and both status flags (bit 0 framing, bit 1 parity) read 0.
- R2: A correctly framed character is written to the FIFO exactly once, as a one-cycle strobe. Data bit k of the line goes to entry bit k (first received bit in bit 0). The bits at and above the configured length (5 to 9) are zero. The entry holds no error indication.
- R3: If the line is high at the middle of the start bit, the framing flag is set, nothing is written to the FIFO, and the receiver goes back to waiting for a falling edge.
- R4: With parity enabled, the parity bit is expected to make the total number of ones in data plus parity even (parity-odd input 0) or odd (parity-odd input 1). A mismatch sets the parity flag.
- R5: A character with a parity mismatch is discarded when drop-on-parity is 1 and written to the FIFO when it is 0.
- R6: A stop bit sampled low sets the framing flag. With two stop bits selected, both are checked.
- R7: A character with a stop-bit error is discarded when drop-on-frame is 1 and written to the FIFO when it is 0.
- R8: After a stop-bit error the receiver accepts no start bit until the line has returned high. A character sent after that is received correctly.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable, 16 per bit period |
| rx_line | input | 1 | Asynchronous serial receive line |
| cfg_data_len | input | 4 | Character length, 5 to 9 (values outside are clamped) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_drop_frame | input | 1 | Discard characters with a stop-bit error |
| cfg_drop_parity | input | 1 | Discard characters with a parity error |
| sts_clr_we | input | 1 | Status write strobe |
| sts_clr_data | input | 2 | Write-one-to-clear mask (bit 0 framing, bit 1 parity) |
| sts_flags | output | 2 | Sticky flags (bit 0 framing, bit 1 parity) |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 9 | Received character, right-aligned |

## Verification
Assertions check several rules on every cycle. A write strobe never lasts two cycles. The unused high data bits are zero. A detected start glitch never coincides with a write. A write never accompanies a framing error under the drop-on-frame policy. The flags also obey set-wins and stickiness on every cycle. Bench scenarios show the rest: bit order and length handling, the even/odd parity computation, both drop policies in both settings, the glitch rejection, the second stop bit, and recovery after a held-low line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_MAX = 9;
    localparam int DATA_MIN = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic frame_err;
        logic parity_err;
    } rx_events_t;

    localparam int FLAG_FRAME  = 0;
    localparam int FLAG_PARITY = 1;

    function automatic logic [3:0] clamp_len(input logic [3:0] len);
        if (len < 4'(DATA_MIN)) return 4'(DATA_MIN);
        if (len > 4'(DATA_MAX)) return 4'(DATA_MAX);
        return len;
    endfunction

    function automatic logic expected_parity(input logic [DATA_MAX-1:0] data,
                                             input logic odd);
        return (^data) ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                rx,
    input  logic [3:0]          cfg_data_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_drop_frame,
    input  logic                cfg_drop_parity,
    output rx_events_t          events,
    output logic                start_glitch,
    output logic                push,
    output logic [DATA_MAX-1:0] push_data
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [3:0]          idx;
    logic [DATA_MAX-1:0] shreg;
    logic                rx_prev;
    logic                par_bad;
    logic                stop_bad;
    logic [3:0]          len;
    logic                stop_now_bad;
    logic                keep;

    assign len          = clamp_len(cfg_data_len);
    assign stop_now_bad = stop_bad | ~rx;
    assign keep         = ~(stop_now_bad & cfg_drop_frame) & ~(par_bad & cfg_drop_parity);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= RX_IDLE;
            cnt          <= '0;
            idx          <= '0;
            shreg        <= '0;
            rx_prev      <= 1'b1;
            par_bad      <= 1'b0;
            stop_bad     <= 1'b0;
            events       <= '0;
            start_glitch <= 1'b0;
            push         <= 1'b0;
            push_data    <= '0;
        end else begin
            events       <= '0;
            start_glitch <= 1'b0;
            push         <= 1'b0;
            if (os_tick) begin
                rx_prev <= rx;
                case (state)
                    RX_IDLE: begin
                        if (rx_prev && !rx) begin
                            state    <= RX_START;
                            cnt      <= '0;
                            shreg    <= '0;
                            par_bad  <= 1'b0;
                            stop_bad <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            idx <= '0;
                            if (rx) begin
                                start_glitch     <= 1'b1;
                                events.frame_err <= 1'b1;
                                state            <= RX_IDLE;
                            end else begin
                                state <= RX_DATA;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            shreg[idx] <= rx;
                            if (idx == len - 4'd1) begin
                                idx   <= '0;
                                state <= cfg_par_en ? RX_PARITY : RX_STOP;
                            end else begin
                                idx <= idx + 4'd1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bad <= (rx != expected_parity(shreg, cfg_par_odd));
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (cfg_two_stop && idx == 4'd0) begin
                                stop_bad <= stop_now_bad;
                                idx      <= 4'd1;
                            end else begin
                                events.frame_err  <= stop_now_bad;
                                events.parity_err <= par_bad;
                                push              <= keep;
                                push_data         <= shreg;
                                state             <= stop_now_bad ? RX_HOLD : RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_HOLD: begin
                        if (rx) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        push |=> !push); // R2
    AST_GLITCH_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        start_glitch |-> (!push && events.frame_err)); // R3
    AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == RX_HOLD && !rx) |=> state == RX_HOLD); // R8
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_events_t events,
    input  logic       clr_we,
    input  logic [1:0] clr_data,
    output logic [1:0] flags
);
    logic [1:0] set_vec;
    logic [1:0] clr_vec;

    assign set_vec[FLAG_FRAME]  = events.frame_err;
    assign set_vec[FLAG_PARITY] = events.parity_err;
    assign clr_vec              = clr_we ? clr_data : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_vec[b] |=> flags[b]); // R9
            AST_STICKY: assert property (@(posedge clk) disable iff (rst)
                (flags[b] && !clr_vec[b]) |=> flags[b]); // R9
            AST_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[b] && !set_vec[b]) |=> !flags[b]); // R9
        end
    endgenerate
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic                rx_line,
    input  logic [3:0]          cfg_data_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    input  logic                cfg_drop_frame,
    input  logic                cfg_drop_parity,
    input  logic                sts_clr_we,
    input  logic [1:0]          sts_clr_data,
    output logic [1:0]          sts_flags,
    output logic                fifo_wr_en,
    output logic [DATA_MAX-1:0] fifo_wr_data
);
    logic       rx_s;
    rx_events_t ev;
    logic       glitch;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(rx_line), .sync_out(rx_s)
    );

    uart_rx_core #(.OSR(OSR)) u_core (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx(rx_s),
        .cfg_data_len(cfg_data_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_drop_frame(cfg_drop_frame), .cfg_drop_parity(cfg_drop_parity),
        .events(ev), .start_glitch(glitch),
        .push(fifo_wr_en), .push_data(fifo_wr_data)
    );

    uart_rx_status u_status (
        .clk(clk), .rst(rst), .events(ev),
        .clr_we(sts_clr_we), .clr_data(sts_clr_data), .flags(sts_flags)
    );

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> ((fifo_wr_data >> clamp_len(cfg_data_len)) == '0)); // R2
    AST_DROP_FRAME: assert property (@(posedge clk) disable iff (rst)
        (ev.frame_err && cfg_drop_frame) |-> !fifo_wr_en); // R7
    AST_DROP_PARITY: assert property (@(posedge clk) disable iff (rst)
        (ev.parity_err && cfg_drop_parity) |-> !fifo_wr_en); // R5
endmodule

// File: tb/uart_rx_engine_tb.sv
module uart_rx_engine_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [3:0] cfg_data_len = 4'd8;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_drop_frame = 1'b0, cfg_drop_parity = 1'b0;
    logic       sts_clr_we = 1'b0;
    logic [1:0] sts_clr_data = 2'b00;
    logic [1:0] sts_flags;
    logic       fifo_wr_en;
    logic [8:0] fifo_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [8:0] exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_engine u_dut (
        .clk(clk), .rst(rst), .os_tick(1'b1), .rx_line(rx_line),
        .cfg_data_len(cfg_data_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .cfg_drop_frame(cfg_drop_frame), .cfg_drop_parity(cfg_drop_parity),
        .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
        .sts_flags(sts_flags), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pop one expected entry per FIFO write
    always @(negedge clk) begin
        if (!rst && fifo_wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R5/R7 unexpected write", int'(fifo_wr_data), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(fifo_wr_data == e, "R2 entry data", int'(fifo_wr_data), int'(e));
            end
        end
    end

    task automatic hold(input logic v, input int cycles);
        rx_line = v;
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    // send one character; parity_flip inverts the parity bit, stop values given
    task automatic send(input logic [8:0] data, input bit parity_flip,
                        input logic stop1, input logic stop2, input bit expect_push);
        logic [8:0] masked;
        logic p;
        masked = data & ((9'h1 << cfg_data_len) - 9'h1);
        if (expect_push) exp_q.push_back(masked);
        hold(1'b0, 16);
        for (int i = 0; i < int'(cfg_data_len); i++) hold(masked[i], 16);
        if (cfg_par_en) begin
            p = (^masked) ^ cfg_par_odd ^ parity_flip;
            hold(p, 16);
        end
        hold(stop1, 16);
        if (cfg_two_stop) hold(stop2, 16);
        hold(1'b1, 40);
    endtask

    task automatic clear_flags(input logic [1:0] m);
        sts_clr_we = 1'b1; sts_clr_data = m;
        @(posedge clk); #1;
        sts_clr_we = 1'b0; sts_clr_data = 2'b00;
        @(posedge clk); #1;
    endtask

    task automatic check_flags(input logic [1:0] exp, input string req);
        check(sts_flags == exp, req, int'(sts_flags), int'(exp));
        check(exp_q.size() == 0, {req, " pending writes"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        // R1 reset state
        check(fifo_wr_en == 1'b0, "R1 write strobe", int'(fifo_wr_en), 0);
        check(sts_flags == 2'b00, "R1 flags", int'(sts_flags), 0);
        hold(1'b1, 20);

        // R2 8 data bits, no parity
        send(9'h0A5, 0, 1, 1, 1);
        send(9'h03C, 0, 1, 1, 1);
        check_flags(2'b00, "R2 8N1 clean");
        cfg_data_len = 4'd5;
        send(9'h1F6, 0, 1, 1, 1);
        check_flags(2'b00, "R2 5-bit length");
        cfg_data_len = 4'd9;
        send(9'h155, 0, 1, 1, 1);
        send(9'h100, 0, 1, 1, 1);
        check_flags(2'b00, "R2 9-bit length");

        // R4 parity good, even and odd
        cfg_data_len = 4'd8; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(9'h0B7, 0, 1, 1, 1);
        cfg_par_odd = 1'b1;
        send(9'h0B7, 0, 1, 1, 1);
        check_flags(2'b00, "R4 good parity");

        // R4/R5 bad parity kept when drop-on-parity = 0
        send(9'h012, 1, 1, 1, 1);
        check_flags(2'b10, "R4 R5 parity error kept");
        // R9 writing 0 leaves flag, writing 1 clears
        clear_flags(2'b01);
        check(sts_flags == 2'b10, "R9 write of 0 to parity bit", int'(sts_flags), 2);
        clear_flags(2'b10);
        check(sts_flags == 2'b00, "R9 write of 1 clears", int'(sts_flags), 0);

        // R5 drop on parity
        cfg_drop_parity = 1'b1; cfg_par_odd = 1'b0;
        send(9'h0C3, 1, 1, 1, 0);
        check_flags(2'b10, "R5 parity error dropped");
        clear_flags(2'b11);
        cfg_par_en = 1'b0; cfg_drop_parity = 1'b0;

        // R6/R7 stop error kept when drop-on-frame = 0
        send(9'h05A, 0, 0, 1, 1);
        check_flags(2'b01, "R6 R7 stop error kept");
        clear_flags(2'b01);

        // R7/R8 stop error dropped, line held low, then recovery
        cfg_drop_frame = 1'b1;
        exp_q.delete();
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(1'b1, 16);
        hold(1'b0, 80);
        hold(1'b1, 40);
        check_flags(2'b01, "R7 stop error dropped");
        clear_flags(2'b01);
        send(9'h081, 0, 1, 1, 1);
        check_flags(2'b00, "R8 recovery after held-low line");

        // R6 second stop bit checked
        cfg_two_stop = 1'b1;
        send(9'h099, 0, 1, 1, 1);
        check_flags(2'b00, "R6 two stop bits clean");
        send(9'h066, 0, 1, 0, 0);
        check_flags(2'b01, "R6 second stop bit low");
        clear_flags(2'b01);
        cfg_two_stop = 1'b0; cfg_drop_frame = 1'b0;

        // R3 start glitch rejected
        hold(1'b0, 4);
        hold(1'b1, 60);
        check_flags(2'b01, "R3 start glitch");
        clear_flags(2'b01);
        send(9'h0E7, 0, 1, 1, 1);
        check_flags(2'b00, "R3 clean frame after glitch");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule